// File: doc/BRIEF.md
# Second-Order Recursive Lowpass Filter

This block is a streaming second-order recursive lowpass filter with fixed coefficients. It has a maximally flat passband and a cutoff at 0.3 of the Nyquist frequency. Each sample arrives with a strobe and is a signed 16-bit Q1.15 value. The block registers one filtered sample of the same format, and that sample appears one clock later with its own strobe.

Each new output is a weighted sum of five terms: the present input, the two inputs before it and the two outputs before it. The coefficients are constants in signed Q2.16. All five products are added at full width in one accumulator. The sum is shifted back to Q1.15 by discarding the low 16 bits, which rounds towards minus infinity. Results outside the 16-bit range are clamped to the nearest limit. Because the feedforward taps sum to the feedback normalisation, the gain at DC is unity.

Top module: `iir2_lowpass`

## Requirements
- R1: On each accepted sample the output is floor((B0·x[n] + B1·x[n-1] + B2·x[n-2] + A1·y[n-1] − A2·y[n-2]) / 65536), clamped to 16 bits. All values are integer Q1.15 samples and Q2.16 coefficients.
- R2: The coefficients are B0 = B2 = 8592, B1 = 17184, A1 = 49007 and A2 = 17840. The feedforward taps are symmetric, so an impulse response begins with B0-weighted terms.
- R3: The reduction to 16 bits discards the low bits with an arithmetic shift. A negative sum therefore rounds down: a first input of −1 gives −1, not 0.
- R4: A result above 32767 is output as 32767, and a result below −32768 is output as −32768. A result is never wrapped.
- R5: While rst_ni is low, valid_o is 0, y_o is 0 and all four history registers are 0. The first output after reset is floor(8592·x[0]/65536).
- R6: valid_o is 1 in exactly the cycle that follows a cycle with valid_i high, and is 0 otherwise.
- R7: A cycle without valid_i leaves y_o and the filter history unchanged.
- R8: The gain at DC is unity. A held constant input settles to within 3 LSB of that input.
- R9: Start from a cleared state and feed the sequence 0.1, 0.2, 0.1, 0.24, 0.12, 0.02, 0.2, 0.15, 0.38, 0.2 in Q1.15. The outputs then track 0.01311, 0.06225, 0.12164, 0.15793, 0.17676, 0.15474, 0.11480, 0.11845, 0.17270, 0.24243 within 6 LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| x_i | input | 16 | Input sample, signed Q1.15 |
| valid_o | output | 1 | Output sample strobe |
| y_o | output | 16 | Filtered sample, signed Q1.15 |

## Verification
The assertions check the following on every cycle:
- valid_o follows valid_i with one cycle of delay.
- An idle cycle freezes both the output and the history registers.
- The input history shifts in order.
- Any out-of-range sum is clamped to the correct limit.

Only the bench scenarios can show the following:
- The numeric result matches the recurrence bit for bit.
- Negative sums round down.
- A held input settles to unity gain.
- Step overshoot saturates at full scale.
- The reference sequence is tracked within a few LSB of the ideal values.

// File: rtl/iir2_pkg.sv
package iir2_pkg;
  // Q2.16 coefficients, rounded to nearest
  localparam int DEF_B0 = 8592;
  localparam int DEF_B1 = 17184;
  localparam int DEF_B2 = 8592;
  localparam int DEF_A1 = 49007;
  localparam int DEF_A2 = 17840;
  localparam int NTAP   = 5;
endpackage

// File: rtl/iir2_mac.sv
module iir2_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 18,
  parameter int ACC_W  = 40,
  parameter int NTAP   = 5,
  parameter logic [NTAP*COEF_W-1:0] COEF_VEC = '0
) (
  input  logic signed [DATA_W-1:0] taps_i [NTAP],
  output logic signed [ACC_W-1:0]  acc_o
);
  logic signed [ACC_W-1:0] prod [NTAP];

  for (genvar g = 0; g < NTAP; g++) begin : g_prod
    localparam logic signed [COEF_W-1:0] C = COEF_VEC[g*COEF_W +: COEF_W];
    assign prod[g] = ACC_W'(taps_i[g]) * ACC_W'(C);
  end

  always_comb begin
    acc_o = '0;
    for (int i = 0; i < NTAP; i++) acc_o = acc_o + prod[i];
  end
endmodule

// File: rtl/iir2_sat.sv
module iir2_sat #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 16
) (
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MIN_V = -ACC_W'(1 << (DATA_W - 1));

  logic signed [ACC_W-1:0] shifted;
  assign shifted = acc_i >>> FRAC_W;  // floor

  always_comb begin
    if (shifted > MAX_V)      y_o = MAX_V[DATA_W-1:0];
    else if (shifted < MIN_V) y_o = MIN_V[DATA_W-1:0];
    else                      y_o = shifted[DATA_W-1:0];
  end

  always_comb begin
    if (shifted > MAX_V) AST_SAT_HIGH: assert (y_o == {1'b0, {(DATA_W-1){1'b1}}}); // R4
    if (shifted < MIN_V) AST_SAT_LOW: assert (y_o == {1'b1, {(DATA_W-1){1'b0}}}); // R4
  end
endmodule

// File: rtl/iir2_lowpass.sv
module iir2_lowpass
  import iir2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 18,
  parameter int FRAC_W = 16,
  parameter int ACC_W  = 40,
  parameter int B0 = DEF_B0,
  parameter int B1 = DEF_B1,
  parameter int B2 = DEF_B2,
  parameter int A1 = DEF_A1,
  parameter int A2 = DEF_A2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] x_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] y_o
);
  // tap order: x[n], x[n-1], x[n-2], y[n-1], y[n-2]; feedback sign folded in
  localparam logic [NTAP*COEF_W-1:0] COEF_VEC =
    {COEF_W'(-A2), COEF_W'(A1), COEF_W'(B2), COEF_W'(B1), COEF_W'(B0)};

  logic signed [DATA_W-1:0] x1_q, x2_q, y2_q;
  logic signed [DATA_W-1:0] taps [NTAP];
  logic signed [ACC_W-1:0]  acc;
  logic signed [DATA_W-1:0] y_next;

  always_comb begin
    taps[0] = x_i;
    taps[1] = x1_q;
    taps[2] = x2_q;
    taps[3] = y_o;   // output register doubles as y[n-1]
    taps[4] = y2_q;
  end

  iir2_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .NTAP(NTAP), .COEF_VEC(COEF_VEC)
  ) u_mac (
    .taps_i(taps),
    .acc_o (acc)
  );

  iir2_sat #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)
  ) u_sat (
    .acc_i(acc),
    .y_o  (y_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q    <= '0;
      x2_q    <= '0;
      y2_q    <= '0;
      y_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        x1_q <= x_i;
        x2_q <= x1_q;
        y2_q <= y_o;
        y_o  <= y_next;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R6
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R6
  AST_HOLD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o)); // R7
  AST_HOLD_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(x1_q) && $stable(x2_q) && $stable(y2_q))); // R7
  AST_X_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (x2_q == $past(x1_q) && x1_q == $past(x_i))); // R1
  AST_Y_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (y2_q == $past(y_o))); // R1
endmodule

// File: tb/iir2_lowpass_tb.sv
`timescale 1ns/1ps
module iir2_lowpass_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic signed [15:0] x_i = '0;
  logic valid_o;
  logic signed [15:0] y_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  longint mx1, mx2, my1, my2;
  longint last_y;
  longint max_seen, min_seen;

  always #4 clk = ~clk;

  iir2_lowpass u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .x_i(x_i),
    .valid_o(valid_o), .y_o(y_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R1/R2/R3/R4 arithmetic from the requirements
  function automatic longint model(input longint x0, x1, x2, y1, y2);
    longint acc, s;
    acc = 8592*x0 + 17184*x1 + 8592*x2 + 49007*y1 - 17840*y2;
    s = acc >>> 16;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    valid_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(valid_o == 1'b0, "R5 valid_o in reset", valid_o, 0);
    chk(y_o == 0, "R5 y_o in reset", y_o, 0);
    rst_n = 1'b1;
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
  endtask

  task automatic step(input bit v, input longint x);
    longint exp, prev;
    valid_i = v;
    x_i = x[15:0];
    prev = y_o;
    @(negedge clk);
    if (v) begin
      exp = model(x, mx1, mx2, my1, my2);
      chk(valid_o == 1'b1, "R6 valid after sample", valid_o, 1);
      chk(y_o == exp, "R1 output value", y_o, exp);
      mx2 = mx1; mx1 = x; my2 = my1; my1 = exp;
    end else begin
      chk(valid_o == 1'b0, "R6 no valid when idle", valid_o, 0);
      chk(y_o == prev, "R7 output held when idle", y_o, prev);
    end
    last_y = y_o;
    if (y_o > max_seen) max_seen = y_o;
    if (y_o < min_seen) min_seen = y_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R6: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    real xin [10] = '{0.1, 0.2, 0.1, 0.24, 0.12, 0.02, 0.2, 0.15, 0.38, 0.2};
    real yref [10] = '{0.01311064, 0.06224657, 0.12164226, 0.15792644, 0.17675735,
                       0.15474052, 0.11479561, 0.11845091, 0.17270089, 0.2424279};
    int unused;
    real maxerr;
    unused = $urandom(32'd20240);
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    repeat (3) @(negedge clk);
    do_reset();

    // R5: first output after reset
    step(1, 1000);
    chk(last_y == 131, "R5 first output", last_y, 131);
    step(0, 0);

    // R3: negative sum rounds down
    do_reset();
    step(1, -1);
    chk(last_y == -1, "R3 floor on negative", last_y, -1);

    // R2: impulse response
    do_reset();
    step(1, 32767);
    chk(last_y == 4295, "R2 impulse first tap", last_y, 4295);
    for (int i = 0; i < 20; i++) step(1, 0);

    // R9: reference sequence
    do_reset();
    maxerr = 0.0;
    for (int i = 0; i < 10; i++) begin
      longint xq, yq;
      real e;
      xq = longint'($rtoi(xin[i] * 32768.0 + 0.5));
      step(1, xq);
      yq = longint'($rtoi(yref[i] * 32768.0 + 0.5));
      e = (last_y - yq) < 0 ? real'(yq - last_y) : real'(last_y - yq);
      if (e > maxerr) maxerr = e;
      chk(e <= 6.0, "R9 reference tracking", last_y, yq);
    end
    $display("R9 max error %0.1f LSB", maxerr);

    // R8: unity DC gain
    do_reset();
    for (int i = 0; i < 80; i++) step(1, 16384);
    chk(last_y >= 16381 && last_y <= 16387, "R8 DC gain positive", last_y, 16384);
    for (int i = 0; i < 80; i++) step(1, -8192);
    chk(last_y >= -8195 && last_y <= -8189, "R8 DC gain negative", last_y, -8192);

    // R4: step overshoot saturates
    do_reset();
    max_seen = -100000; min_seen = 100000;
    for (int i = 0; i < 30; i++) step(1, 32767);
    chk(max_seen == 32767, "R4 clamp high", max_seen, 32767);
    for (int i = 0; i < 30; i++) step(1, -32768);
    chk(min_seen == -32768, "R4 clamp low", min_seen, -32768);

    // R6/R7: random stream with gaps
    do_reset();
    for (int i = 0; i < 400; i++) begin
      bit v;
      longint x;
      v = ($urandom % 4) != 0;
      if (i % 50 < 25) x = longint'($signed(16'($urandom)));
      else x = longint'($signed(16'($urandom))) >>> 3;
      step(v, x);
    end
    step(0, 0);
    step(0, 0);

    // R7: history unchanged across an idle run, then resumes exactly
    do_reset();
    step(1, 12000);
    step(1, -7000);
    for (int i = 0; i < 10; i++) step(0, 30000);
    step(1, 500);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule